// File: doc/BRIEF.md
# Paged Receive Ring Buffer Writer

This block accepts incoming frames as a byte stream and stores them in a circular buffer in on-chip RAM. The buffer is divided into 256-byte pages. A frame always starts on a page boundary. Its first four bytes are reserved for a status header, and the frame bytes follow straight after that header. Frames may run past the last page of the ring and continue at the first page. When a frame ends, the block writes the header, advances its current-page pointer to the page after the frame, and raises a frame-received flag.

Software drains the ring through a direct read port into the RAM. Software keeps a boundary page that trails its own read position by one page. The writer never enters the boundary page. If a frame would need that page, the block drops the frame, leaves the current page where it was, and raises an overflow flag. A small byte-wide register port sets up and observes the ring pointers, the interrupt flags and their mask.

The sender must leave at least four idle cycles after the last byte of a frame, because the header is written during those cycles.

Top module: `rxring_writer`

## Requirements
- R1: After reset the registers read as follows: start page 0, stop page PAGE_COUNT, boundary page PAGE_COUNT-1, current page 0, interrupt status 0 and interrupt mask 0. The interrupt output is low.
- R2: The register addresses are 0 for start page, 1 for stop page, 2 for boundary, 3 for current page, 4 for interrupt status and 5 for interrupt mask. The start, stop, boundary, current page and mask registers read back the value last written to them. All other addresses read as 0.
- R3: Frame bytes are stored at consecutive addresses, beginning at byte offset 4 of the current page.
- R4: The 4-byte header sits at offsets 0 to 3 of the page where the frame began. It is written only after the last frame byte has arrived. The current page keeps its old value for at least two cycles after the last byte, and changes only when the header is complete.
- R5: Header byte 0 is the status byte. Its bits are sampled with the last byte of the frame: bit 0 set means no error was flagged, bit 1 is the CRC error, bit 2 is the alignment error and bit 3 is the FIFO overrun. Bits 7 to 4 are 0.
- R6: Header bytes 2 and 3 hold the low and high bytes of the number of bytes received, trailing CRC bytes included.
- R7: Header byte 1, and the new current page, is the page that follows the page holding the last frame byte. A frame that ends exactly at the end of a page therefore points to the next page. Completing a frame sets interrupt status bit 0.
- R8: Moving on from page stop-1 goes to the start page. A frame that crosses this point continues at offset 0 of the start page.
- R9: If any move to a new page, including the final round-up to the next page, would land on the boundary page, the block sets interrupt status bit 1. In that case the frame is discarded, no header is written, the current page and the boundary page contents stay unchanged, and the remaining bytes of that frame are ignored.
- R10: Interrupt status bits are write-1-to-clear. Writing a 0 to a bit leaves it unchanged.
- R11: The interrupt output is high exactly when some interrupt status bit is set and its mask bit in the same position is set.
- R12: The host read port returns the RAM byte at the given address one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | A frame byte is present this cycle |
| rxData | input | 8 | Frame byte |
| rxLast | input | 1 | This byte ends the frame |
| rxErrCrc | input | 1 | CRC error flag, valid with rxLast |
| rxErrAlign | input | 1 | Alignment error flag, valid with rxLast |
| rxErrOverrun | input | 1 | FIFO overrun flag, valid with rxLast |
| regAddr | input | 3 | Register select |
| regWe | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| hostAddr | input | ADDR_W | Buffer RAM read address |
| hostRdData | output | 8 | Buffer RAM read data, one cycle later |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench uses the default PAGE_COUNT of 8, which gives 2 KiB of buffer RAM. Through the registers it narrows the ring to pages 1 to 5. With a ring that small, a 300-byte frame wraps from page 5 back to page 1, and a frame of a few hundred bytes reaches the boundary page. This brings within reach both kinds of overflow: one in the middle of a frame and one at the final round-up. The bench also sends a frame that fills its page exactly, and frames carrying each error flag, so that every status bit and the next-page rule are seen in the header.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_HDR,
    ST_DROP
  } rxState_t;

  typedef struct packed {
    logic       startFrame;
    logic       writeByte;
    logic       writeHdr;
    logic [1:0] hdrSel;
    logic       commit;
    logic       raiseOvf;
  } ctlStrobe_t;

  localparam logic [2:0] REG_START = 3'd0;
  localparam logic [2:0] REG_STOP  = 3'd1;
  localparam logic [2:0] REG_BNRY  = 3'd2;
  localparam logic [2:0] REG_CURR  = 3'd3;
  localparam logic [2:0] REG_ISR   = 3'd4;
  localparam logic [2:0] REG_IMR   = 3'd5;

  localparam int HDR_BYTES = 4;

endpackage

// File: rtl/rxring_ram.sv
module rxring_ram #(
  parameter int ADDR_W = 11,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       rxLast,
  input  logic       wouldOverflow,
  output ctlStrobe_t strobe
);

  rxState_t   state, nextState;
  logic [1:0] hdrIdx;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE, ST_DATA: begin
        if (rxValid) begin
          strobe.startFrame = (state == ST_IDLE);
          strobe.writeByte  = 1'b1;
          if (wouldOverflow) begin
            strobe.raiseOvf = 1'b1;
            nextState       = rxLast ? ST_IDLE : ST_DROP;
          end else if (rxLast) begin
            nextState = ST_HDR;
          end else begin
            nextState = ST_DATA;
          end
        end
      end
      ST_HDR: begin
        strobe.writeHdr = 1'b1;
        strobe.hdrSel   = hdrIdx;
        if (hdrIdx == 2'd3) begin
          strobe.commit = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      ST_DROP: begin
        if (rxValid && rxLast) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hdrIdx <= 2'd0;
    end else begin
      state  <= nextState;
      hdrIdx <= (state == ST_HDR) ? hdrIdx + 2'd1 : 2'd0;
    end
  end

endmodule

// File: rtl/rxring_dpath.sv
module rxring_dpath
  import rxring_pkg::*;
#(
  parameter int PAGE_COUNT = 8,
  localparam int PAGE_W = $clog2(PAGE_COUNT),
  localparam int ADDR_W = PAGE_W + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  input  logic              rxErrCrc,
  input  logic              rxErrAlign,
  input  logic              rxErrOverrun,
  input  logic [2:0]        regAddr,
  input  logic              regWe,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              wouldOverflow,
  output logic              irq,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [7:0]        ramWrData,
  output logic [7:0]        startPage,
  output logic [7:0]        stopPage,
  output logic [7:0]        bnryPage,
  output logic [7:0]        currPage,
  output logic [1:0]        intStatus
);

  localparam logic [7:0] RST_STOP = 8'(PAGE_COUNT);
  localparam logic [7:0] RST_BNRY = 8'(PAGE_COUNT - 1);

  logic [1:0]        intMask;
  logic [7:0]        wrPage, wrOff;
  logic [15:0]       byteCnt;
  logic [PAGE_W-1:0] frameStart;
  logic [7:0]        hdrStatus, hdrNext;
  logic [15:0]       hdrLen;

  logic [7:0]  effPage, effOff, incEff, newOff;
  logic [15:0] effCnt;
  logic [7:0]  hdrByte;
  logic [1:0]  isrClear;

  function automatic logic [7:0] incPage(input logic [7:0] p);
    logic [7:0] q;
    q = p + 8'd1;
    return (q == stopPage) ? startPage : q;
  endfunction

  always_comb begin
    effPage       = strobe.startFrame ? currPage : wrPage;
    effOff        = strobe.startFrame ? 8'(HDR_BYTES) : wrOff;
    effCnt        = strobe.startFrame ? 16'd0 : byteCnt;
    incEff        = incPage(effPage);
    newOff        = effOff + 8'd1;
    wouldOverflow = ((newOff == 8'd0) || rxLast) && (incEff == bnryPage);
  end

  always_comb begin
    unique case (strobe.hdrSel)
      2'd0:    hdrByte = hdrStatus;
      2'd1:    hdrByte = hdrNext;
      2'd2:    hdrByte = hdrLen[7:0];
      default: hdrByte = hdrLen[15:8];
    endcase
  end

  always_comb begin
    ramWe     = strobe.writeByte | strobe.writeHdr;
    ramAddr   = strobe.writeHdr ? {frameStart, 6'd0, strobe.hdrSel}
                                : {effPage[PAGE_W-1:0], effOff};
    ramWrData = strobe.writeHdr ? hdrByte : rxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPage     <= '0;
      wrOff      <= '0;
      byteCnt    <= '0;
      frameStart <= '0;
      hdrStatus  <= '0;
      hdrNext    <= '0;
      hdrLen     <= '0;
    end else if (strobe.writeByte) begin
      wrOff   <= newOff;
      wrPage  <= (newOff == 8'd0) ? incEff : effPage;
      byteCnt <= effCnt + 16'd1;
      if (strobe.startFrame) frameStart <= currPage[PAGE_W-1:0];
      if (rxLast) begin
        hdrStatus <= {4'd0, rxErrOverrun, rxErrAlign, rxErrCrc,
                      ~(rxErrOverrun | rxErrAlign | rxErrCrc)};
        hdrNext   <= incEff;
        hdrLen    <= effCnt + 16'd1;
      end
    end
  end

  assign isrClear = (regWe && regAddr == REG_ISR) ? regWrData[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPage <= 8'd0;
      stopPage  <= RST_STOP;
      bnryPage  <= RST_BNRY;
      currPage  <= 8'd0;
      intStatus <= 2'b00;
      intMask   <= 2'b00;
    end else begin
      intStatus <= (intStatus & ~isrClear) | {strobe.raiseOvf, strobe.commit};
      if (regWe) begin
        unique case (regAddr)
          REG_START: startPage <= regWrData;
          REG_STOP:  stopPage  <= regWrData;
          REG_BNRY:  bnryPage  <= regWrData;
          REG_CURR:  currPage  <= regWrData;
          REG_IMR:   intMask   <= regWrData[1:0];
          default: ;
        endcase
      end
      if (strobe.commit) currPage <= hdrNext;
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_START: regRdData = startPage;
      REG_STOP:  regRdData = stopPage;
      REG_BNRY:  regRdData = bnryPage;
      REG_CURR:  regRdData = currPage;
      REG_ISR:   regRdData = {6'd0, intStatus};
      REG_IMR:   regRdData = {6'd0, intMask};
      default:   regRdData = 8'd0;
    endcase
  end

  assign irq = |(intStatus & intMask);

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int PAGE_COUNT = 8,
  localparam int ADDR_W = $clog2(PAGE_COUNT) + 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  input  logic              rxErrCrc,
  input  logic              rxErrAlign,
  input  logic              rxErrOverrun,
  input  logic [2:0]        regAddr,
  input  logic              regWe,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic [7:0]        hostRdData,
  output logic              irq
);

  ctlStrobe_t        strobe;
  logic              wouldOverflow;
  logic              ramWe;
  logic [ADDR_W-1:0] ramAddr;
  logic [7:0]        ramWrData;
  logic [7:0]        startPage, stopPage, bnryPage, currPage;
  logic [1:0]        intStatus;

  rxring_ctrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .rxValid       (rxValid),
    .rxLast        (rxLast),
    .wouldOverflow (wouldOverflow),
    .strobe        (strobe)
  );

  rxring_dpath #(.PAGE_COUNT(PAGE_COUNT)) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .rxData        (rxData),
    .rxLast        (rxLast),
    .rxErrCrc      (rxErrCrc),
    .rxErrAlign    (rxErrAlign),
    .rxErrOverrun  (rxErrOverrun),
    .regAddr       (regAddr),
    .regWe         (regWe),
    .regWrData     (regWrData),
    .regRdData     (regRdData),
    .wouldOverflow (wouldOverflow),
    .irq           (irq),
    .ramWe         (ramWe),
    .ramAddr       (ramAddr),
    .ramWrData     (ramWrData),
    .startPage     (startPage),
    .stopPage      (stopPage),
    .bnryPage      (bnryPage),
    .currPage      (currPage),
    .intStatus     (intStatus)
  );

  rxring_ram #(.ADDR_W(ADDR_W)) uRam (
    .clk    (clk),
    .wrEn   (ramWe),
    .wrAddr (ramAddr),
    .wrData (ramWrData),
    .rdAddr (hostAddr),
    .rdData (hostRdData)
  );

endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk
  import rxring_pkg::*;
#(
  parameter int PAGE_COUNT = 8,
  localparam int PAGE_W = $clog2(PAGE_COUNT),
  localparam int ADDR_W = PAGE_W + 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        regAddr,
  input logic              regWe,
  input logic              irq,
  input ctlStrobe_t        strobe,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic [7:0]        startPage,
  input logic [7:0]        stopPage,
  input logic [7:0]        bnryPage,
  input logic [7:0]        currPage,
  input logic [1:0]        intStatus
);

  AST_NO_BOUNDARY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ramAddr[ADDR_W-1:8] != bnryPage[PAGE_W-1:0]); // R9

  AST_OVF_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.raiseOvf |=> intStatus[1]); // R9

  AST_COMMIT_AFTER_HDR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> ramWe && ramAddr[7:0] == 8'd3); // R4

  AST_CURR_MOVES_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(currPage) |-> $past(strobe.commit) ||
                           ($past(regWe) && $past(regAddr) == REG_CURR)); // R4

  AST_RX_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> intStatus[0]); // R7

  AST_CURR_IN_RING: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> currPage >= startPage && currPage < stopPage); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> intStatus != 2'b00); // R11

endmodule

bind rxring_writer rxring_writer_chk #(.PAGE_COUNT(PAGE_COUNT)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWe     (regWe),
  .irq       (irq),
  .strobe    (strobe),
  .ramWe     (ramWe),
  .ramAddr   (ramAddr),
  .startPage (startPage),
  .stopPage  (stopPage),
  .bnryPage  (bnryPage),
  .currPage  (currPage),
  .intStatus (intStatus)
);

// File: tb/rxring_writer_test.sv
module rxring_writer_test;

  localparam int PAGE_COUNT = 8;
  localparam int AW = $clog2(PAGE_COUNT) + 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rxValid = 1'b0, rxLast = 1'b0;
  logic [7:0]    rxData = 8'd0;
  logic          rxErrCrc = 1'b0, rxErrAlign = 1'b0, rxErrOverrun = 1'b0;
  logic [2:0]    regAddr = 3'd0;
  logic          regWe = 1'b0;
  logic [7:0]    regWrData = 8'd0;
  logic [7:0]    regRdData;
  logic [AW-1:0] hostAddr = '0;
  logic [7:0]    hostRdData;
  logic          irq;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  rxring_writer #(.PAGE_COUNT(PAGE_COUNT)) uut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxLast(rxLast),
    .rxErrCrc(rxErrCrc), .rxErrAlign(rxErrAlign), .rxErrOverrun(rxErrOverrun),
    .regAddr(regAddr), .regWe(regWe), .regWrData(regWrData), .regRdData(regRdData),
    .hostAddr(hostAddr), .hostRdData(hostRdData), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic memRd(input int a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = AW'(a);
    @(negedge clk);
    d = hostRdData;
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(i * 7 + seed);
  endfunction

  task automatic sendFrame(input int n, input int seed, input bit crc,
                           input bit aln, input bit ovr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = pat(seed, i); rxLast = (i == n - 1);
      rxErrCrc = crc && (i == n - 1);
      rxErrAlign = aln && (i == n - 1);
      rxErrOverrun = ovr && (i == n - 1);
      @(posedge clk);
    end
    @(negedge clk);
    rxValid = 1'b0; rxLast = 1'b0;
    rxErrCrc = 1'b0; rxErrAlign = 1'b0; rxErrOverrun = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic checkHeader(input string req, input int page, input int st,
                             input int nxt, input int len);
    logic [7:0] d;
    memRd(page * 256 + 0, d); check({req, " R5 status"}, d, st);
    memRd(page * 256 + 1, d); check({req, " R7 next page"}, d, nxt);
    memRd(page * 256 + 2, d); check({req, " R6 length low"}, d, len & 255);
    memRd(page * 256 + 3, d); check({req, " R6 length high"}, d, len >> 8);
  endtask

  task automatic testReset();
    logic [7:0] d;
    regRd(3'd0, d); check("R1 start", d, 0);
    regRd(3'd1, d); check("R1 stop", d, PAGE_COUNT);
    regRd(3'd2, d); check("R1 boundary", d, PAGE_COUNT - 1);
    regRd(3'd3, d); check("R1 current", d, 0);
    regRd(3'd4, d); check("R1 isr", d, 0);
    regRd(3'd5, d); check("R1 imr", d, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic testRegs();
    logic [7:0] d;
    regWr(3'd0, 8'd1); regWr(3'd1, 8'd6); regWr(3'd2, 8'd5); regWr(3'd3, 8'd1);
    regWr(3'd5, 8'd2);
    regRd(3'd0, d); check("R2 start", d, 1);
    regRd(3'd1, d); check("R2 stop", d, 6);
    regRd(3'd2, d); check("R2 boundary", d, 5);
    regRd(3'd3, d); check("R2 current", d, 1);
    regRd(3'd5, d); check("R2 imr", d, 2);
    regRd(3'd7, d); check("R2 unused address", d, 0);
    regWr(3'd5, 8'd0);
  endtask

  task automatic testBasicFrame();
    logic [7:0] d;
    sendFrame(70, 3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    regAddr = 3'd3;
    #1 check("R4 current held during header", regRdData, 1);
    settle();
    regRd(3'd3, d); check("R7 current advanced", d, 2);
    regRd(3'd4, d); check("R7 rx flag", d, 1);
    checkHeader("basic", 1, 8'h01, 2, 70);
    memRd(12'h104, d); check("R3 first byte", d, pat(3, 0));
    memRd(12'h104 + 69, d); check("R3 last byte", d, pat(3, 69));
    memRd(12'h104 + 30, d); check("R12 host read", d, pat(3, 30));
  endtask

  task automatic testErrorFrames();
    logic [7:0] d;
    sendFrame(60, 9, 1'b1, 1'b0, 1'b0);
    settle();
    checkHeader("crc", 2, 8'h02, 3, 60);
    sendFrame(61, 11, 1'b0, 1'b1, 1'b1);
    settle();
    checkHeader("align+overrun", 3, 8'h0C, 4, 61);
    regRd(3'd3, d); check("R7 current after errors", d, 4);
  endtask

  task automatic testW1C();
    logic [7:0] d;
    regWr(3'd4, 8'h00);
    regRd(3'd4, d); check("R10 write 0 keeps flag", d, 1);
    regWr(3'd4, 8'h01);
    regRd(3'd4, d); check("R10 write 1 clears flag", d, 0);
  endtask

  task automatic testWrap();
    logic [7:0] d;
    regWr(3'd3, 8'd5); regWr(3'd2, 8'd4);
    sendFrame(300, 21, 1'b0, 1'b0, 1'b0);
    settle();
    checkHeader("wrap", 5, 8'h01, 2, 300);
    memRd(12'h5FF, d); check("R8 byte at end of stop-1 page", d, pat(21, 251));
    memRd(12'h100, d); check("R8 byte continues at start page", d, pat(21, 252));
    memRd(12'h100 + 47, d); check("R8 last wrapped byte", d, pat(21, 299));
    regRd(3'd3, d); check("R8 current after wrap", d, 2);
    regWr(3'd4, 8'h03);
  endtask

  task automatic testOverflowMid();
    logic [7:0] d, b0, b1;
    memRd(12'h400, b0); memRd(12'h4FF, b1);
    sendFrame(600, 40, 1'b0, 1'b0, 1'b0);
    settle();
    regRd(3'd4, d); check("R9 overflow flag only", d, 2);
    regRd(3'd3, d); check("R9 current unchanged", d, 2);
    memRd(12'h400, d); check("R9 boundary page start untouched", d, b0);
    memRd(12'h4FF, d); check("R9 boundary page end untouched", d, b1);
    check("R11 irq masked off", irq, 0);
    regWr(3'd5, 8'h01);
    check("R11 irq other bit enabled", irq, 0);
    regWr(3'd5, 8'h02);
    check("R11 irq ovf enabled", irq, 1);
    regWr(3'd4, 8'h02);
    check("R11 irq after clear", irq, 0);
    regRd(3'd4, d); check("R10 overflow cleared", d, 0);
  endtask

  task automatic testOverflowRound();
    logic [7:0] d;
    sendFrame(300, 50, 1'b0, 1'b0, 1'b0);
    settle();
    regRd(3'd4, d); check("R9 round-up overflow", d, 2);
    regRd(3'd3, d); check("R9 current unchanged after round-up", d, 2);
    regWr(3'd4, 8'h02);
  endtask

  task automatic testExactFill();
    logic [7:0] d;
    sendFrame(252, 60, 1'b0, 1'b0, 1'b0);
    settle();
    checkHeader("exact fill", 2, 8'h01, 3, 252);
    regRd(3'd3, d); check("R7 current after exact fill", d, 3);
    memRd(12'h2FF, d); check("R3 last byte of full page", d, pat(60, 251));
    regWr(3'd5, 8'h01);
    check("R11 irq on rx flag", irq, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testBasicFrame();
    testErrorFrames();
    testW1C();
    testWrap();
    testOverflowMid();
    testOverflowRound();
    testExactFill();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule